// File: doc/BRIEF.md
# Handshaked Two-Tap Averaging Filter

This block is a streaming filter that sits between two four-phase request/acknowledge channels. Each sample that arrives on the input channel is averaged with the sample that came before it. The result, `(x + y) / 2`, leaves on the output channel. The block starts with a remembered sample of zero, so the first result is half of the first input.

The design is synchronous. One small sequencer plays the part of the self-timed control. It runs four steps in a fixed order: capture the new sample, form the average, hold it on the output channel until the consumer acknowledges it, and only then replace the remembered sample with the captured one. Both channels must return to zero before the next sample is taken. Upstream may change its data as soon as it sees the input acknowledge.

Top module: `avg2_stream`

## Requirements
- R1: After reset, `in_ack` and `out_req` are low and the remembered sample is zero, so the first result equals the first input shifted right by one.
- R2: Each result is `(x + y) >> 1`. Here `x` is the accepted sample and `y` is the sample accepted just before it. The sum is formed in `W+1` bits and halved by truncation, and inputs are unsigned.
- R3: `in_ack` rises only after `in_req` has been seen high and the sample has been captured. Changes on `in_data` after `in_ack` is high do not alter the result.
- R4: Once `in_ack` is high, it falls only after `in_req` has been seen low.
- R5: `out_req` rises only after `in_ack` has risen for the same sample, so capture precedes the add.
- R6: While `out_req` is high and `out_ack` is low, `out_data` holds its value.
- R7: `out_req` falls only after `out_ack` has been seen high.
- R8: No new sample is accepted (`in_ack` stays low even with `in_req` high) until `out_ack` has returned low.
- R9: The remembered sample is replaced only after the output acknowledge. The result of every sample is therefore based on the previously accepted sample, whatever the channel timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_req | input | 1 | Input request; marks `in_data` valid |
| in_data | input | W | Input sample, unsigned |
| in_ack | output | 1 | Input acknowledge |
| out_req | output | 1 | Output request; marks `out_data` valid |
| out_data | output | W | Averaged result |
| out_ack | input | 1 | Output acknowledge |

## Verification
The bench sends a 4-bit configuration every ordered pair of samples, so every carry into the extra sum bit and every truncated odd sum shows up. A design that dropped the carry would return small averages for large inputs. One that rounded would be one too high on odd sums. The bench corrupts `in_data` right after the acknowledge: a design that read the input late would follow the garbage. It also raises a new request while the old output acknowledge is still high. A design that ignored the return-to-zero rule would accept early. If it also updated `y` too early, the average would pair with the wrong sample. Acknowledge delays vary from sample to sample, and the output is watched for changes during those waits.

// File: rtl/avg2_stream.sv
module avg2_stream #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_req,
  input  logic [W-1:0] in_data,
  output logic         in_ack,
  output logic         out_req,
  output logic [W-1:0] out_data,
  input  logic         out_ack
);

  typedef enum logic [1:0] {S_IDLE, S_ADD, S_SEND, S_DONE} step_t;

  step_t        step;
  logic [W-1:0] x_q, y_q, res_q;
  logic [W:0]   sum;

  assign sum      = {1'b0, x_q} + {1'b0, y_q};
  assign out_data = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step    <= S_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      res_q   <= '0;
      in_ack  <= 1'b0;
      out_req <= 1'b0;
    end else begin
      if (in_ack && !in_req) in_ack <= 1'b0;
      case (step)
        S_IDLE: if (in_req && !in_ack && !out_ack) begin
          x_q    <= in_data;
          in_ack <= 1'b1;
          step   <= S_ADD;
        end
        S_ADD: begin
          res_q   <= sum[W:1];
          out_req <= 1'b1;
          step    <= S_SEND;
        end
        S_SEND: if (out_ack) begin
          out_req <= 1'b0;
          y_q     <= x_q;
          step    <= S_DONE;
        end
        default: if (!in_ack && !out_ack) step <= S_IDLE;
      endcase
    end
  end

  a_r3_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_req));
  a_r4_ack_fall_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ack) |-> $past(!in_req));
  a_r5_capture_before_emit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> $past(in_ack));
  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> $stable(out_data));
  a_r7_req_fall_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_req) |-> $past(out_ack));
  a_r8_wait_return_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(!out_ack) && $past(!out_req));

endmodule

// File: tb/sim_avg2_stream.sv
module sim_avg2_stream;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_req = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ack;
  logic         out_req;
  logic [W-1:0] out_data;
  logic         out_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  int prev_y = 0;

  always #10 clk = ~clk;

  avg2_stream #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
    .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int x, input int dly);
    int exp_v;
    bit seen_ack;
    in_data = x[W-1:0];
    in_req  = 1'b1;
    if (out_ack) begin
      repeat (3) begin
        @(negedge clk);
        check(!in_ack, "R8", in_ack, 0);
      end
      out_ack = 1'b0;
    end
    seen_ack = 1'b0;
    while (!in_ack) begin
      @(negedge clk);
      if (out_req && !in_ack) check(0, "R5", out_req, 0);
    end
    seen_ack = 1'b1;
    in_data = ~x[W-1:0];
    while (!out_req) @(negedge clk);
    check(seen_ack, "R5", seen_ack, 1);
    exp_v = (x + prev_y) >> 1;
    check(out_data == exp_v, "R2 R3 R9", out_data, exp_v);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check(out_data == exp_v, "R6", out_data, exp_v);
      check(out_req, "R7", out_req, 1);
    end
    check(in_ack, "R4", in_ack, 1);
    out_ack = 1'b1;
    @(negedge clk);
    in_req = 1'b0;
    while (in_ack || out_req) @(negedge clk);
    prev_y = x;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!in_ack && !out_req, "R1", {in_ack, out_req}, 0);
    send(13, 1);
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        send(a, (a + b) % 3);
        send(b, (a * b) % 4);
      end
    end
    out_ack = 1'b0;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule